// File: doc/BRIEF.md
# Predicated Vector Scatter Store Sequencer

This block turns a single vector store command into a series of single-word memory writes. A command carries several things: a 64-bit scalar base, a vector of 32-bit indices, a vector of 32-bit data words and a per-lane enable mask. It also carries a bit that selects how each index is widened, a bit that enables a multiply-by-four, and a flag that says the base came from the stack pointer. For every enabled lane, the block forms a target address and presents that address with the lane's data word on a valid/ready write port.

Lanes are visited from the lowest number upward, and lanes whose mask bit is clear are skipped. When the command is finished, a one-cycle completion strobe is raised. A stack-pointer base must be aligned to 16 bytes. A misaligned stack-pointer base cancels the whole command and raises an error strobe together with completion. If no lane is enabled, a configuration input decides whether that alignment rule still applies. The block keeps no condition flags.

Top module: `vec_scatter_seq`

## Requirements
- R1: Exactly one write handshake occurs for each lane whose mask bit is 1, and none for lanes whose bit is 0.
- R2: Writes go out in strictly ascending lane order, where lane i holds index bits [32i+31:32i] and data bits [32i+31:32i].
- R3: The write address is base + (widened index << s), computed modulo 2^64. s is 2 when the scale bit is 1 and 0 otherwise.
- R4: The index is sign-extended from 32 to 64 bits when cmd_sext is 1 and zero-extended when it is 0.
- R5: With cmd_scale at 0 the widened index is added unshifted. With cmd_scale at 1 it is multiplied by 4.
- R6: While wr_valid is 1 and wr_ready is 0, wr_valid stays 1 and wr_addr and wr_data stay unchanged. The block moves to the next lane only after a handshake.
- R7: A command with an all-zero mask and no alignment fault raises done with no write and with err low.
- R8: With cmd_base_sp at 1, a nonzero mask and base bits [3:0] not all zero, the command issues no writes and raises err together with done. With the base aligned, it proceeds normally.
- R9: With cmd_base_sp at 1, an all-zero mask and a misaligned base, err is raised only when cfg_chk_empty is 1. Either way, no write is issued.
- R10: cmd_ready is 1 only when idle. All command inputs are captured in the cycle of acceptance, and later changes to them have no effect on the running command.
- R11: After reset the block is idle: cmd_ready 1, wr_valid 0, done 0. done and err are high for exactly one cycle per command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command taken when valid |
| cmd_base | input | 64 | Scalar base address |
| cmd_base_sp | input | 1 | Base was taken from the stack pointer |
| cmd_index | input | LANES*32 | Per-lane indices, lane 0 in the low bits |
| cmd_data | input | LANES*32 | Per-lane data words, lane 0 in the low bits |
| cmd_mask | input | LANES | Lane enables, bit i for lane i |
| cmd_sext | input | 1 | 1 sign-extends indices, 0 zero-extends |
| cmd_scale | input | 1 | 1 multiplies indices by 4 |
| cfg_chk_empty | input | 1 | Apply the alignment rule when no lane is enabled |
| wr_valid | output | 1 | Word write presented |
| wr_ready | input | 1 | Memory accepts the word write |
| wr_addr | output | 64 | Word write address |
| wr_data | output | 32 | Word write data |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | One-cycle alignment fault, coincident with done |

## Verification
The hardest case to reach is a write port stall in the middle of a sparse mask. To be observed, the held address has to survive several cycles while the next enabled lane is not the adjacent one. The stimulus gets there by drawing wr_ready low with a chosen probability on every cycle and by mixing masks with gaps, such as lanes 0 and 7 only. A second hard area is the empty-mask alignment corner. It needs the stack-pointer flag, a misaligned base and both values of the configuration input together, so it is reached with directed commands. The commands also keep cmd_valid high with scrambled fields while the block is busy, which shows that those fields were captured at acceptance.

// File: rtl/scatter_pkg.sv
package scatter_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } seq_st_e;
endpackage

// File: rtl/scatter_lane_pick.sv
module scatter_lane_pick #(
    parameter int LANES = 8,
    localparam int LW = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [LANES-1:0] pend,
    output logic             any,
    output logic [LW-1:0]    lane
);
    always_comb begin
        lane = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (pend[i]) lane = LW'(i);
        end
    end

    assign any = |pend;
endmodule

// File: rtl/scatter_addr_gen.sv
module scatter_addr_gen #(
    parameter int ADDR_W   = 64,
    parameter int IDX_W    = 32,
    parameter int SCALE_SH = 2
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  idx,
    input  logic              sext,
    input  logic              scale,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] wide;

    generate
        if (ADDR_W > IDX_W) begin : g_widen
            localparam int PAD = ADDR_W - IDX_W;
            assign wide = {{PAD{sext & idx[IDX_W-1]}}, idx};
        end else begin : g_same
            assign wide = idx[ADDR_W-1:0];
        end
    endgenerate

    assign addr = base + (scale ? (wide << SCALE_SH) : wide);
endmodule

// File: rtl/scatter_align_chk.sv
module scatter_align_chk #(
    parameter int ADDR_W      = 64,
    parameter int ALIGN_BYTES = 16,
    localparam int AB = (ALIGN_BYTES > 1) ? $clog2(ALIGN_BYTES) : 1
) (
    input  logic [ADDR_W-1:0] base,
    input  logic              base_sp,
    input  logic              any_active,
    input  logic              chk_empty,
    output logic              fault
);
    assign fault = base_sp && (|base[AB-1:0]) && (any_active || chk_empty);
endmodule

// File: rtl/vec_scatter_seq.sv
module vec_scatter_seq
    import scatter_pkg::*;
#(
    parameter int LANES       = 8,
    parameter int IDX_W       = 32,
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 64,
    parameter int ALIGN_BYTES = 16,
    parameter int SCALE_SH    = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_valid,
    output logic                    cmd_ready,
    input  logic [ADDR_W-1:0]       cmd_base,
    input  logic                    cmd_base_sp,
    input  logic [LANES*IDX_W-1:0]  cmd_index,
    input  logic [LANES*DATA_W-1:0] cmd_data,
    input  logic [LANES-1:0]        cmd_mask,
    input  logic                    cmd_sext,
    input  logic                    cmd_scale,
    input  logic                    cfg_chk_empty,
    output logic                    wr_valid,
    input  logic                    wr_ready,
    output logic [ADDR_W-1:0]       wr_addr,
    output logic [DATA_W-1:0]       wr_data,
    output logic                    done,
    output logic                    err
);
    localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;

    typedef struct packed {
        seq_st_e                 st;
        logic [ADDR_W-1:0]       base;
        logic [LANES*IDX_W-1:0]  idx;
        logic [LANES*DATA_W-1:0] dat;
        logic [LANES-1:0]        pend;
        logic                    sext;
        logic                    scale;
        logic                    err;
    } seq_t;

    seq_t cur_q, cur_d;

    logic          any_w;
    logic [LW-1:0] lane_w;
    logic          fault_w;
    logic [ADDR_W-1:0] addr_w;

    scatter_lane_pick #(.LANES(LANES)) u_pick (
        .pend (cur_q.pend),
        .any  (any_w),
        .lane (lane_w)
    );

    scatter_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .SCALE_SH(SCALE_SH)) u_agen (
        .base  (cur_q.base),
        .idx   (cur_q.idx[lane_w*IDX_W +: IDX_W]),
        .sext  (cur_q.sext),
        .scale (cur_q.scale),
        .addr  (addr_w)
    );

    scatter_align_chk #(.ADDR_W(ADDR_W), .ALIGN_BYTES(ALIGN_BYTES)) u_align (
        .base       (cmd_base),
        .base_sp    (cmd_base_sp),
        .any_active (|cmd_mask),
        .chk_empty  (cfg_chk_empty),
        .fault      (fault_w)
    );

    always_comb begin
        cur_d = cur_q;
        unique case (cur_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    cur_d.base  = cmd_base;
                    cur_d.idx   = cmd_index;
                    cur_d.dat   = cmd_data;
                    cur_d.sext  = cmd_sext;
                    cur_d.scale = cmd_scale;
                    cur_d.err   = fault_w;
                    cur_d.pend  = fault_w ? '0 : cmd_mask;
                    cur_d.st    = fault_w ? ST_FIN : ST_RUN;
                end
            end
            ST_RUN: begin
                if (!any_w) begin
                    cur_d.st = ST_FIN;
                end else if (wr_ready) begin
                    cur_d.pend[lane_w] = 1'b0;
                end
            end
            ST_FIN: begin
                cur_d.st  = ST_IDLE;
                cur_d.err = 1'b0;
            end
            default: cur_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= cur_d;
        end
    end

    assign cmd_ready = (cur_q.st == ST_IDLE);
    assign wr_valid  = (cur_q.st == ST_RUN) && any_w;
    assign wr_addr   = addr_w;
    assign wr_data   = cur_q.dat[lane_w*DATA_W +: DATA_W];
    assign done      = (cur_q.st == ST_FIN);
    assign err       = (cur_q.st == ST_FIN) && cur_q.err;

    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

    // R2
    lane_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_ready |=> !wr_valid || (lane_w > $past(lane_w)));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done && !wr_valid);

    // R10
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid || done) |-> !cmd_ready);

    // R7
    fin_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready && !fault_w && cmd_mask == '0 |=> !wr_valid);
endmodule

// File: tb/sim_vec_scatter_seq.sv
module sim_vec_scatter_seq;
    localparam int LANES = 8;
    localparam int VW = LANES * 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic cmd_ready;
    logic [63:0] cmd_base = '0;
    logic cmd_base_sp = 1'b0;
    logic [VW-1:0] cmd_index = '0;
    logic [VW-1:0] cmd_data = '0;
    logic [LANES-1:0] cmd_mask = '0;
    logic cmd_sext = 1'b0;
    logic cmd_scale = 1'b0;
    logic cfg_chk_empty = 1'b0;
    logic wr_valid;
    logic wr_ready = 1'b0;
    logic [63:0] wr_addr;
    logic [31:0] wr_data;
    logic done;
    logic err;

    int n_chk = 0;
    int n_err = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    vec_scatter_seq #(.LANES(LANES)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_base(cmd_base), .cmd_base_sp(cmd_base_sp),
        .cmd_index(cmd_index), .cmd_data(cmd_data), .cmd_mask(cmd_mask),
        .cmd_sext(cmd_sext), .cmd_scale(cmd_scale), .cfg_chk_empty(cfg_chk_empty),
        .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .done(done), .err(err)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] lane_addr(input logic [63:0] b, input logic [31:0] ix,
                                              input logic sg, input logic sc);
        logic [63:0] w;
        w = sg ? {{32{ix[31]}}, ix} : {32'h0, ix};
        if (sc) w = w * 64'd4;
        return b + w;
    endfunction

    function automatic logic [VW-1:0] rnd_vec();
        logic [VW-1:0] v;
        for (int i = 0; i < LANES; i++) v[i*32 +: 32] = $urandom();
        return v;
    endfunction

    task automatic run_cmd(input logic [63:0] b, input logic sp, input logic [VW-1:0] ix,
                           input logic [VW-1:0] dt, input logic [LANES-1:0] m,
                           input logic sg, input logic sc, input logic ce, input int pct);
        logic [63:0] ea [LANES];
        logic [31:0] ed [LANES];
        int n;
        int k;
        bit exp_err;
        bit stalled;
        bit busy_ok;
        bit fin;
        logic [63:0] paddr;
        logic [31:0] pdata;
        exp_err = sp && (b[3:0] != 4'h0) && ((m != '0) || ce);
        n = 0;
        if (!exp_err) begin
            for (int i = 0; i < LANES; i++) begin
                if (m[i]) begin
                    ea[n] = lane_addr(b, ix[i*32 +: 32], sg, sc);
                    ed[n] = dt[i*32 +: 32];
                    n++;
                end
            end
        end
        @(negedge clk);
        chk(cmd_ready === 1'b1, "R10 idle ready", 64'(cmd_ready), 64'd1);
        cmd_valid = 1'b1; cmd_base = b; cmd_base_sp = sp; cmd_index = ix; cmd_data = dt;
        cmd_mask = m; cmd_sext = sg; cmd_scale = sc; cfg_chk_empty = ce;
        @(negedge clk);
        // R10: scrambled fields offered while busy must be ignored
        cmd_base = {$urandom(), $urandom()}; cmd_base_sp = ~sp; cmd_index = rnd_vec();
        cmd_data = rnd_vec(); cmd_mask = ~m; cmd_sext = ~sg; cmd_scale = ~sc; cfg_chk_empty = ~ce;
        k = 0; stalled = 0; busy_ok = 1; fin = 0; paddr = '0; pdata = '0;
        for (int cyc = 0; cyc < 2000; cyc++) begin
            if (done === 1'b1) begin fin = 1; break; end
            if (cmd_ready !== 1'b0) busy_ok = 0;
            if (stalled) begin
                chk(wr_valid === 1'b1, "R6 valid held", 64'(wr_valid), 64'd1);
                chk(wr_addr === paddr, "R6 addr held", wr_addr, paddr);
                chk(wr_data === pdata, "R6 data held", 64'(wr_data), 64'(pdata));
            end
            wr_ready = (($urandom() % 100) < pct);
            stalled = 0;
            if (wr_valid === 1'b1) begin
                if (wr_ready) begin
                    if (k >= n) begin
                        chk(0, "R1 extra write", 64'(k + 1), 64'(n));
                    end else begin
                        chk(wr_addr === ea[k], "R3 R2 address", wr_addr, ea[k]);
                        chk(wr_data === ed[k], "R2 data", 64'(wr_data), 64'(ed[k]));
                    end
                    k++;
                end else begin
                    stalled = 1; paddr = wr_addr; pdata = wr_data;
                end
            end
            @(negedge clk);
        end
        chk(fin, "R1 completion watchdog", 64'(fin), 64'd1);
        chk(busy_ok, "R10 ready low while busy", 64'(busy_ok), 64'd1);
        chk(k == n, "R1 R7 write count", 64'(k), 64'(n));
        chk(err === exp_err, "R8 R9 error flag", 64'(err), 64'(exp_err));
        cmd_valid = 1'b0; wr_ready = 1'b0;
        @(negedge clk);
        chk(done === 1'b0 && err === 1'b0, "R11 one-cycle done", 64'({done, err}), 64'd0);
    endtask

    initial begin
        wait (cycles > 150000);
        chk(0, "watchdog", 64'(cycles), 64'd150000);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [VW-1:0] ix;
        logic [VW-1:0] dt;
        void'($urandom(32'h5CA7_7E21));
        repeat (3) @(negedge clk);
        chk(wr_valid === 1'b0 && done === 1'b0, "R11 reset outputs", 64'({wr_valid, done}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_ready === 1'b1, "R11 idle after reset", 64'(cmd_ready), 64'd1);

        dt = rnd_vec();
        // R7 empty mask, no stack-pointer base
        run_cmd(64'h1003, 1'b0, rnd_vec(), dt, 8'h00, 1'b1, 1'b1, 1'b1, 100);
        // R9 empty mask, misaligned stack-pointer base, check off then on
        run_cmd(64'h2008, 1'b1, rnd_vec(), dt, 8'h00, 1'b0, 1'b0, 1'b0, 100);
        run_cmd(64'h2008, 1'b1, rnd_vec(), dt, 8'h00, 1'b0, 1'b0, 1'b1, 100);
        // R9 empty mask, aligned stack-pointer base, check on: no error
        run_cmd(64'h2010, 1'b1, rnd_vec(), dt, 8'h00, 1'b0, 1'b0, 1'b1, 100);
        // R8 misaligned stack-pointer base with active lanes
        run_cmd(64'h3004, 1'b1, rnd_vec(), dt, 8'h05, 1'b0, 1'b1, 1'b0, 100);
        // R8 aligned stack-pointer base proceeds
        run_cmd(64'h3000, 1'b1, rnd_vec(), dt, 8'hFF, 1'b0, 1'b1, 1'b0, 100);
        // R4 R5 negative indices, signed and scaled
        ix = '0;
        for (int i = 0; i < LANES; i++) ix[i*32 +: 32] = 32'hFFFF_FFF0 + 32'(i);
        run_cmd(64'h0000_0000_0001_0000, 1'b0, ix, dt, 8'hFF, 1'b1, 1'b1, 1'b0, 100);
        // R4 R5 same indices, zero-extended and unscaled
        run_cmd(64'h0000_0000_0001_0000, 1'b0, ix, dt, 8'hFF, 1'b0, 1'b0, 1'b0, 100);
        // R3 wrap modulo 2^64
        for (int i = 0; i < LANES; i++) ix[i*32 +: 32] = 32'h20 + 32'(4 * i);
        run_cmd(64'hFFFF_FFFF_FFFF_FFF0, 1'b0, ix, dt, 8'hAA, 1'b0, 1'b1, 1'b0, 100);
        // R6 R2 sparse mask under heavy stalls
        run_cmd(64'h4000, 1'b0, rnd_vec(), rnd_vec(), 8'h81, 1'b1, 1'b0, 1'b0, 25);
        run_cmd(64'h4400, 1'b0, rnd_vec(), rnd_vec(), 8'h24, 1'b0, 1'b1, 1'b0, 10);

        for (int t = 0; t < 200; t++) begin
            int pct;
            logic [63:0] b;
            pct = (t % 3 == 0) ? 100 : ((t % 3 == 1) ? 50 : 20);
            b = {$urandom(), $urandom()};
            if ($urandom() % 2 == 0) b[3:0] = 4'h0;
            run_cmd(b, 1'($urandom()), rnd_vec(), rnd_vec(), 8'($urandom()),
                    1'($urandom()), 1'($urandom()), 1'($urandom()), pct);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule